// File: doc/BRIEF.md
# Two-Stage Supervisory Watchdog

This block guards a small controller against runaway firmware. A 16-bit down-counter starts counting instruction-cycle ticks as soon as system reset is released and keeps running whether or not supervision is on. Each time it wraps past zero it emits a one-cycle pulse, which a neighbouring timer can use as its count source. The counter is never reloaded by software.

Firmware turns supervision on with its first service strobe, and nothing but a system reset or a back-up entry can turn it off again. Two checkpoints sit half a counter period apart: the tick that moves the count to BFFFh and the tick that moves it to 3FFFh. Once supervision is on, a checkpoint raises a warning flag, and a service strobe clears that flag. If a checkpoint arrives while the warning flag is still set, a fault flag is raised and the reset output is pulled low. The reset output stays low until system reset is applied. Firmware therefore has to service within one checkpoint spacing of 32768 ticks. Entering the low-power back-up state reloads the counter and clears all flags.

Top module: `wdt2_top`

## Requirements
- R1: While `rst` is high, and after its release, `arm_flag`, `warn_flag`, `bite_flag` and `uf_pulse` are 0, `sys_rst_n_out` is 1 and the count is FFFFh.
- R2: The count drops by one on each clock edge where `tick_en` is 1 and holds otherwise, whether or not the watchdog is armed.
- R3: A tick taken at count 0000h wraps the count to FFFFh and makes `uf_pulse` 1 for exactly the following cycle. This is the 65536th tick after FFFFh.
- R4: `svc_strobe` sets `arm_flag`. Once set, `arm_flag` stays 1 until `rst` or `backup_enter`.
- R5: While `arm_flag` is 0, checkpoints have no effect, so `warn_flag` and `bite_flag` stay 0.
- R6: While armed, a tick that moves the count to BFFFh or 3FFFh sets `warn_flag` in the cycle after that tick.
- R7: A service strobe clears `warn_flag` and leaves the count unchanged.
- R8: A checkpoint reached while `warn_flag` is 1 sets `bite_flag` and drives `sys_rst_n_out` to 0.
- R9: When a service strobe and a checkpoint fall on the same edge, the service wins: `warn_flag` ends at 1 and `bite_flag` is not set.
- R10: `backup_enter` reloads the count to FFFFh and clears `arm_flag`, `warn_flag` and `bite_flag`. It overrides a concurrent service strobe and tick.
- R11: Once `sys_rst_n_out` is 0, it stays 0 through `backup_enter` and returns to 1 only on `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick_en | input | 1 | Instruction-cycle tick, one count per high cycle |
| svc_strobe | input | 1 | Firmware service strobe |
| backup_enter | input | 1 | Entry into the low-power back-up state |
| uf_pulse | output | 1 | One-cycle wrap pulse for a neighbouring timer |
| arm_flag | output | 1 | Supervision enabled (sticky) |
| warn_flag | output | 1 | First-stage warning |
| bite_flag | output | 1 | Second-stage fault |
| sys_rst_n_out | output | 1 | Active-low reset request, held until `rst` |

## Verification
A service strobe and a checkpoint can land on the same clock edge, and the block must then favour the service. The bench provokes this by letting a checkpoint set the warning flag. It then counts ticks to the next checkpoint and pulses `svc_strobe` together with exactly that tick. The expected outcome is a warning flag still set, no fault flag and the reset output still high. A second collision puts back-up entry, a service strobe and a tick on one edge. The expected outcome is that all flags are clear, and that the next warning comes exactly 16384 ticks after re-arming, which shows the counter was reloaded.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_TOP  = '1;
    localparam cnt_t CNT_ZERO = '0;

    typedef struct packed {
        logic arm;
        logic warn;
        logic bite;
    } sup_flags_t;

    localparam sup_flags_t FLAGS_CLEAR = '{arm: 1'b0, warn: 1'b0, bite: 1'b0};

    // True when the next tick lands on a checkpoint (BFFFh or 3FFFh):
    // the count is 4000h or C000h.
    function automatic logic next_is_ckpt(input cnt_t c);
        return (c[CNT_W-3:0] == '0) && c[CNT_W-2];
    endfunction

endpackage

// File: rtl/wdt2_counter.sv
module wdt2_counter
    import wdt2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic backup_enter,
    input  logic tick_en,
    output logic uf_pulse,
    output logic ckpt_hit
);

    cnt_t count_q;
    logic uf_q;

    always_ff @(posedge clk) begin
        if (rst || backup_enter) begin
            count_q <= CNT_TOP;
            uf_q    <= 1'b0;
        end else if (tick_en) begin
            if (count_q == CNT_ZERO) begin
                count_q <= CNT_TOP;
                uf_q    <= 1'b1;
            end else begin
                count_q <= count_q - 1'b1;
                uf_q    <= 1'b0;
            end
        end else begin
            uf_q <= 1'b0;
        end
    end

    assign uf_pulse = uf_q;
    assign ckpt_hit = tick_en && next_is_ckpt(count_q);

endmodule

// File: rtl/wdt2_supervisor.sv
module wdt2_supervisor
    import wdt2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       backup_enter,
    input  logic       svc_strobe,
    input  logic       ckpt_hit,
    output sup_flags_t flags,
    output logic       hold_low
);

    sup_flags_t flags_q;
    sup_flags_t flags_d;
    logic       hold_q;
    logic       live_hit;

    assign live_hit = ckpt_hit && flags_q.arm;

    always_comb begin
        flags_d = flags_q;
        if (svc_strobe) begin
            flags_d.arm  = 1'b1;
            flags_d.warn = live_hit;   // service wins; a coinciding checkpoint opens a new window
        end else if (live_hit) begin
            flags_d.warn = 1'b1;
            if (flags_q.warn) begin
                flags_d.bite = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_CLEAR;
            hold_q  <= 1'b0;
        end else if (backup_enter) begin
            flags_q <= FLAGS_CLEAR;
        end else begin
            flags_q <= flags_d;
            if (flags_d.bite) begin
                hold_q <= 1'b1;
            end
        end
    end

    assign flags    = flags_q;
    assign hold_low = hold_q;

endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic svc_strobe,
    input  logic backup_enter,
    output logic uf_pulse,
    output logic arm_flag,
    output logic warn_flag,
    output logic bite_flag,
    output logic sys_rst_n_out
);

    logic       ckpt_hit;
    sup_flags_t flags;
    logic       hold_low;

    wdt2_counter u_counter (
        .clk          (clk),
        .rst          (rst),
        .backup_enter (backup_enter),
        .tick_en      (tick_en),
        .uf_pulse     (uf_pulse),
        .ckpt_hit     (ckpt_hit)
    );

    wdt2_supervisor u_super (
        .clk          (clk),
        .rst          (rst),
        .backup_enter (backup_enter),
        .svc_strobe   (svc_strobe),
        .ckpt_hit     (ckpt_hit),
        .flags        (flags),
        .hold_low     (hold_low)
    );

    assign arm_flag      = flags.arm;
    assign warn_flag     = flags.warn;
    assign bite_flag     = flags.bite;
    assign sys_rst_n_out = !hold_low;

endmodule

// File: rtl/wdt2_chk.sv
module wdt2_chk (
    input logic clk,
    input logic rst,
    input logic svc_strobe,
    input logic backup_enter,
    input logic uf_pulse,
    input logic arm_flag,
    input logic warn_flag,
    input logic bite_flag,
    input logic sys_rst_n_out
);

    AST_UF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        uf_pulse |=> !uf_pulse);                                          // R3

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (arm_flag && !backup_enter) |=> arm_flag);                        // R4

    AST_SVC_ARMS: assert property (@(posedge clk) disable iff (rst)
        (svc_strobe && !backup_enter) |=> arm_flag);                      // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !arm_flag |-> (!warn_flag && !bite_flag));                        // R5

    AST_BITE_AFTER_WARN: assert property (@(posedge clk) disable iff (rst)
        $rose(bite_flag) |-> $past(warn_flag));                           // R8

    AST_BITE_DRIVES_OUT: assert property (@(posedge clk) disable iff (rst)
        bite_flag |-> !sys_rst_n_out);                                    // R8

    AST_BACKUP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        backup_enter |=> (!arm_flag && !warn_flag && !bite_flag && !uf_pulse)); // R10

    AST_OUT_LATCHED: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_n_out |=> !sys_rst_n_out);                               // R11

endmodule

bind wdt2_top wdt2_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .svc_strobe    (svc_strobe),
    .backup_enter  (backup_enter),
    .uf_pulse      (uf_pulse),
    .arm_flag      (arm_flag),
    .warn_flag     (warn_flag),
    .bite_flag     (bite_flag),
    .sys_rst_n_out (sys_rst_n_out)
);

// File: tb/tb_wdt2_top.sv
module tb_wdt2_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic svc_strobe = 1'b0;
    logic backup_enter = 1'b0;
    logic uf_pulse, arm_flag, warn_flag, bite_flag, sys_rst_n_out;

    always #2 clk = ~clk;   // 250 MHz

    wdt2_top dut (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .svc_strobe    (svc_strobe),
        .backup_enter  (backup_enter),
        .uf_pulse      (uf_pulse),
        .arm_flag      (arm_flag),
        .warn_flag     (warn_flag),
        .bite_flag     (bite_flag),
        .sys_rst_n_out (sys_rst_n_out)
    );

    typedef struct {
        string tag;
        logic  uf, arm, warn, bite, rstn;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_cycles = 0;

    // Reference state, built from the requirements
    int   m_cnt;
    logic m_uf, m_arm, m_warn, m_bite, m_hold;

    task automatic model_reset();
        m_cnt = 16'hFFFF; m_uf = 0; m_arm = 0; m_warn = 0; m_bite = 0; m_hold = 0;
    endtask

    task automatic model_step(input logic t, input logic s, input logic b);
        logic hit;
        if (b) begin
            m_cnt = 16'hFFFF; m_uf = 0; m_arm = 0; m_warn = 0; m_bite = 0;
        end else begin
            hit  = t && m_arm && (m_cnt == 16'hC000 || m_cnt == 16'h4000);
            m_uf = t && (m_cnt == 0);
            if (t) m_cnt = (m_cnt == 0) ? 16'hFFFF : m_cnt - 1;
            if (s) begin
                m_arm  = 1;
                m_warn = hit;
            end else if (hit) begin
                if (m_warn) begin
                    m_bite = 1;
                    m_hold = 1;
                end
                m_warn = 1;
            end
        end
    endtask

    // Driver: one clock, inputs applied at the falling edge
    task automatic cyc(input logic t, input logic s, input logic b);
        tick_en = t; svc_strobe = s; backup_enter = b;
        @(posedge clk);
        if (rst) model_reset(); else model_step(t, s, b);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        e.tag = tag; e.uf = m_uf; e.arm = m_arm; e.warn = m_warn;
        e.bite = m_bite; e.rstn = !m_hold;
        exp_q.push_back(e);
    endtask

    // Monitor: compares queued expectations against the outputs
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            #0.5;
            e = exp_q.pop_front();
            n_checks++;
            if ({uf_pulse, arm_flag, warn_flag, bite_flag, sys_rst_n_out} !==
                {e.uf, e.arm, e.warn, e.bite, e.rstn}) begin
                n_fail++;
                $display("FAIL %s: actual uf/arm/warn/bite/rstn=%b%b%b%b%b expected=%b%b%b%b%b",
                         e.tag, uf_pulse, arm_flag, warn_flag, bite_flag, sys_rst_n_out,
                         e.uf, e.arm, e.warn, e.bite, e.rstn);
            end
        end
    end

    task automatic finish_run();
        wait (exp_q.size() == 0);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 199000) begin
            n_fail++;
            $display("FAIL watchdog: actual=still running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset(3);
        expect_now("R1 reset state");

        // R2: ticks on alternate cycles only (5 ticks), still unarmed
        for (int i = 0; i < 10; i++) cyc(logic'(i % 2), 1'b0, 1'b0);
        expect_now("R2 gated count");

        // R5: pass the BFFFh checkpoint (tick 16384) while unarmed
        run(16384 - 5 + 10);
        expect_now("R5 unarmed checkpoint ignored");

        // R4: arm, then re-strobe, then idle
        cyc(1'b0, 1'b1, 1'b0);
        expect_now("R4 service arms");
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        expect_now("R4 arm sticky");

        // R6: 3FFFh is reached on tick 49152
        run(49152 - 16394 - 1);
        expect_now("R6 one tick before checkpoint");
        run(1);
        expect_now("R6 warn at 3FFFh");

        // R7: service clears warn without a tick; count keeps running
        cyc(1'b0, 1'b1, 1'b0);
        expect_now("R7 service clears warn");

        // R3: wrap on tick 65536; R7: no reload by the service
        run(65536 - 49152 - 1);
        expect_now("R3 at zero, no pulse yet");
        run(1);
        expect_now("R3 underflow pulse");
        run(1);
        expect_now("R3 pulse one cycle");

        // R6: next checkpoint BFFFh at tick 81920 with warn clear
        run(81920 - 65537);
        expect_now("R6 warn at BFFFh");

        // R8: no service until 3FFFh at tick 114688
        run(114688 - 81920 - 1);
        expect_now("R8 before second checkpoint");
        run(1);
        expect_now("R8 bite and reset low");

        // R10/R11: back-up clears flags, reset output holds
        cyc(1'b0, 1'b0, 1'b1);
        expect_now("R10 R11 backup with output held");
        cyc(1'b1, 1'b0, 1'b0);
        expect_now("R11 still held");
        do_reset(2);
        expect_now("R11 released by reset");

        // Phase 2: R9 collision of service and checkpoint
        cyc(1'b0, 1'b1, 1'b0);
        run(16384);
        expect_now("R6 warn at BFFFh after rearm");
        run(49152 - 16384 - 1);
        cyc(1'b1, 1'b1, 1'b0);
        expect_now("R9 service wins at checkpoint");

        // R10: backup beats a concurrent service and tick, then reloads count
        run(5);
        cyc(1'b1, 1'b1, 1'b1);
        expect_now("R10 backup overrides service");
        cyc(1'b0, 1'b1, 1'b0);
        run(16383);
        expect_now("R10 reloaded: no warn at tick 16383");
        run(1);
        expect_now("R10 reloaded: warn at tick 16384");

        finish_run();
    end

endmodule